// File: doc/BRIEF.md
# Password-Gated Clock Control Register Bank

This block is the register front end of a clock manager. A host reaches it through a single-cycle valid/write/address/data bus that covers an 8 KiB window, addressed in bytes and decoded as 32-bit words. The bank holds the configuration words for a set of PLLs, their output channels and a row of clock multiplexers. Every store carries a key in its top byte, and a store whose key is wrong changes nothing at all. The key byte is never kept. Stored words read back with that byte as zero.

One word is not stored. The lock word is assembled at read time from two bits per PLL: an analog-reset bit in the PLL's shared control word and a power-down bit in its analog word. Every accepted store to a word owned by a PLL, a channel or a multiplexer raises a one-cycle update strobe toward that target, so the dividers downstream can reload. A store to a PLL's shared control word reaches the PLL and every channel that hangs off it. Bus accesses that are misaligned or narrower than a word are refused and flagged.

Top module: `clkreg_bank`

## Requirements
- R1: After reset every stored word reads 0, the lock word reads all ones in its low NUM_PLL bits, and bus_rvalid, bus_err and all strobes are 0.
- R2: A write whose bus_wdata[31:24] differs from 0x5A changes no stored word and raises no strobe.
- R3: An accepted write stores bus_wdata[23:0], and reading the word back returns {8'h00, bus_wdata[23:0]}.
- R4: An access is legal only if bus_addr[1:0] is 0 and bus_size is 2'b10 (4 bytes). The other size codes are 2'b00 for 1 byte, 2'b01 for 2 bytes and 2'b11 reserved. An illegal access raises bus_err in the following cycle and for that cycle only. An illegal read returns rdata 0 with rvalid. An illegal write stores nothing and raises no strobe.
- R5: Every read request produces bus_rvalid with bus_rdata in the following cycle, for one cycle. Word indices outside the map read 0, and writes to them have no effect and raise no strobe. The map gives each target its word index (bus_addr[12:2]): lock 0, PLL shared control 8+p, PLL analog 16+p, channel 32+c, mux control 64+2m, mux divisor 65+2m.
- R6: Reading word 0 returns a 1 in bit p exactly when bit 16 (power-down) of PLL analog word p and bit 8 (analog reset) of PLL shared control word p are both 0. Bits above NUM_PLL are 0, and writes to word 0 do not alter what it reads.
- R7: An accepted write to PLL shared control word p pulses pll_upd[p] and ch_upd[c] for every channel c with c / CH_PER_PLL == p.
- R8: An accepted write to PLL analog word p pulses pll_upd[p] only.
- R9: An accepted write to channel word c pulses ch_upd[c] only.
- R10: An accepted write to the control word or the divisor word of mux m pulses mux_upd[m] only.
- R11: Each strobe is high for exactly the one cycle after the accepted write, and no strobe is raised in a cycle that does not follow a write request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 13 | Byte address inside the window |
| bus_size | input | 2 | Access width code (2'b10 = 32 bits) |
| bus_wdata | input | 32 | Write data, key in bits 31:24 |
| bus_rvalid | output | 1 | Read response valid |
| bus_rdata | output | 32 | Read response data |
| bus_err | output | 1 | One-cycle flag for a refused access |
| pll_upd | output | 4 | Per-PLL update strobes |
| ch_upd | output | 8 | Per-channel update strobes |
| mux_upd | output | 4 | Per-mux update strobes |

## Verification
The bench builds the bank with its default parameters: four PLLs with two channels each and four multiplexers. With that configuration the whole 2048-word window can be written and read back one word at a time, so every mapped and unmapped index is covered. All 256 combinations of the per-PLL reset and power-down bits are driven through the lock word. Every misaligned offset and every size code is also tried against a live register, with the expected strobes and data derived arithmetically from the map.

// File: rtl/clkreg_pkg.sv
package clkreg_pkg;

    localparam int unsigned BUS_W = 32;

    typedef enum logic [1:0] {
        ACC_B8   = 2'd0,
        ACC_B16  = 2'd1,
        ACC_B32  = 2'd2,
        ACC_RSVD = 2'd3
    } acc_size_e;

endpackage

// File: rtl/clkreg_decode.sv
module clkreg_decode
    import clkreg_pkg::*;
#(
    parameter int unsigned ADDR_W     = 13,
    parameter int unsigned NUM_PLL    = 4,
    parameter int unsigned NUM_CH     = 8,
    parameter int unsigned NUM_MUX    = 4,
    parameter int unsigned PW_W       = 8,
    parameter logic [7:0]  PW_KEY     = 8'h5A,
    parameter int unsigned LOCK_IDX   = 0,
    parameter int unsigned PLLCM_IDX  = 8,
    parameter int unsigned PLLANA_IDX = 16,
    parameter int unsigned CH_IDX     = 32,
    parameter int unsigned MUX_IDX    = 64
) (
    input  logic                valid_i,
    input  logic                write_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [1:0]          size_i,
    input  logic [PW_W-1:0]     pw_i,
    output logic                wr_go_o,
    output logic                rd_go_o,
    output logic                bad_o,
    output logic                hit_lock_o,
    output logic [NUM_PLL-1:0]  hit_pcm_o,
    output logic [NUM_PLL-1:0]  hit_pana_o,
    output logic [NUM_CH-1:0]   hit_ch_o,
    output logic [NUM_MUX-1:0]  hit_mctl_o,
    output logic [NUM_MUX-1:0]  hit_mdiv_o
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             legal;
    logic             key_ok;

    assign idx    = addr_i[ADDR_W-1:2];
    assign legal  = (addr_i[1:0] == 2'b00) && (size_i == ACC_B32);
    assign key_ok = (pw_i == PW_KEY[PW_W-1:0]);

    assign wr_go_o    = valid_i && write_i && legal && key_ok;
    assign rd_go_o    = valid_i && !write_i && legal;
    assign bad_o      = valid_i && !legal;
    assign hit_lock_o = (idx == IDX_W'(LOCK_IDX));

    for (genvar p = 0; p < NUM_PLL; p++) begin : g_pll
        assign hit_pcm_o[p]  = (idx == IDX_W'(PLLCM_IDX + p));
        assign hit_pana_o[p] = (idx == IDX_W'(PLLANA_IDX + p));
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign hit_ch_o[c] = (idx == IDX_W'(CH_IDX + c));
    end

    for (genvar m = 0; m < NUM_MUX; m++) begin : g_mux
        assign hit_mctl_o[m] = (idx == IDX_W'(MUX_IDX + 2 * m));
        assign hit_mdiv_o[m] = (idx == IDX_W'(MUX_IDX + 2 * m + 1));
    end

endmodule

// File: rtl/clkreg_store.sv
module clkreg_store #(
    parameter int unsigned NUM_PLL = 4,
    parameter int unsigned NUM_CH  = 8,
    parameter int unsigned NUM_MUX = 4,
    parameter int unsigned KEEP_W  = 24
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_go_i,
    input  logic [KEEP_W-1:0]                wdata_i,
    input  logic [NUM_PLL-1:0]               hit_pcm_i,
    input  logic [NUM_PLL-1:0]               hit_pana_i,
    input  logic [NUM_CH-1:0]                hit_ch_i,
    input  logic [NUM_MUX-1:0]               hit_mctl_i,
    input  logic [NUM_MUX-1:0]               hit_mdiv_i,
    output logic [NUM_PLL-1:0][KEEP_W-1:0]   pcm_o,
    output logic [NUM_PLL-1:0][KEEP_W-1:0]   pana_o,
    output logic [NUM_CH-1:0][KEEP_W-1:0]    ch_o,
    output logic [NUM_MUX-1:0][KEEP_W-1:0]   mctl_o,
    output logic [NUM_MUX-1:0][KEEP_W-1:0]   mdiv_o
);

    typedef struct packed {
        logic [NUM_PLL-1:0][KEEP_W-1:0] pcm;
        logic [NUM_PLL-1:0][KEEP_W-1:0] pana;
        logic [NUM_CH-1:0][KEEP_W-1:0]  ch;
        logic [NUM_MUX-1:0][KEEP_W-1:0] mctl;
        logic [NUM_MUX-1:0][KEEP_W-1:0] mdiv;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_go_i) begin
            for (int p = 0; p < NUM_PLL; p++) begin
                if (hit_pcm_i[p])  st_d.pcm[p]  = wdata_i;
                if (hit_pana_i[p]) st_d.pana[p] = wdata_i;
            end
            for (int c = 0; c < NUM_CH; c++) begin
                if (hit_ch_i[c]) st_d.ch[c] = wdata_i;
            end
            for (int m = 0; m < NUM_MUX; m++) begin
                if (hit_mctl_i[m]) st_d.mctl[m] = wdata_i;
                if (hit_mdiv_i[m]) st_d.mdiv[m] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pcm_o  = st_q.pcm;
    assign pana_o = st_q.pana;
    assign ch_o   = st_q.ch;
    assign mctl_o = st_q.mctl;
    assign mdiv_o = st_q.mdiv;

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_go_i |=> $stable(st_q)); // R2

endmodule

// File: rtl/clkreg_rdmux.sv
module clkreg_rdmux
    import clkreg_pkg::*;
#(
    parameter int unsigned NUM_PLL    = 4,
    parameter int unsigned NUM_CH     = 8,
    parameter int unsigned NUM_MUX    = 4,
    parameter int unsigned KEEP_W     = 24,
    parameter int unsigned ANARST_BIT = 8,
    parameter int unsigned PWRDN_BIT  = 16
) (
    input  logic                            rd_go_i,
    input  logic                            hit_lock_i,
    input  logic [NUM_PLL-1:0]              hit_pcm_i,
    input  logic [NUM_PLL-1:0]              hit_pana_i,
    input  logic [NUM_CH-1:0]               hit_ch_i,
    input  logic [NUM_MUX-1:0]              hit_mctl_i,
    input  logic [NUM_MUX-1:0]              hit_mdiv_i,
    input  logic [NUM_PLL-1:0][KEEP_W-1:0]  pcm_i,
    input  logic [NUM_PLL-1:0][KEEP_W-1:0]  pana_i,
    input  logic [NUM_CH-1:0][KEEP_W-1:0]   ch_i,
    input  logic [NUM_MUX-1:0][KEEP_W-1:0]  mctl_i,
    input  logic [NUM_MUX-1:0][KEEP_W-1:0]  mdiv_i,
    output logic [BUS_W-1:0]                rdata_o
);

    logic [NUM_PLL-1:0] lock_vec;
    logic [BUS_W-1:0]   word;

    always_comb begin
        for (int p = 0; p < NUM_PLL; p++) begin
            lock_vec[p] = !pana_i[p][PWRDN_BIT] && !pcm_i[p][ANARST_BIT];
        end
    end

    always_comb begin
        word = '0;
        if (hit_lock_i) word = BUS_W'(lock_vec);
        for (int p = 0; p < NUM_PLL; p++) begin
            if (hit_pcm_i[p])  word = word | BUS_W'(pcm_i[p]);
            if (hit_pana_i[p]) word = word | BUS_W'(pana_i[p]);
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (hit_ch_i[c]) word = word | BUS_W'(ch_i[c]);
        end
        for (int m = 0; m < NUM_MUX; m++) begin
            if (hit_mctl_i[m]) word = word | BUS_W'(mctl_i[m]);
            if (hit_mdiv_i[m]) word = word | BUS_W'(mdiv_i[m]);
        end
        rdata_o = rd_go_i ? word : '0;
    end

endmodule

// File: rtl/clkreg_bank.sv
module clkreg_bank
    import clkreg_pkg::*;
#(
    parameter int unsigned WIN_BYTES  = 8192,
    parameter int unsigned NUM_PLL    = 4,
    parameter int unsigned CH_PER_PLL = 2,
    parameter int unsigned NUM_MUX    = 4,
    parameter int unsigned PW_W       = 8,
    parameter logic [7:0]  PW_KEY     = 8'h5A,
    parameter int unsigned ANARST_BIT = 8,
    parameter int unsigned PWRDN_BIT  = 16,
    parameter int unsigned LOCK_IDX   = 0,
    parameter int unsigned PLLCM_IDX  = 8,
    parameter int unsigned PLLANA_IDX = 16,
    parameter int unsigned CH_IDX     = 32,
    parameter int unsigned MUX_IDX    = 64,
    localparam int unsigned ADDR_W    = $clog2(WIN_BYTES),
    localparam int unsigned NUM_CH    = NUM_PLL * CH_PER_PLL
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [1:0]          bus_size,
    input  logic [31:0]         bus_wdata,
    output logic                bus_rvalid,
    output logic [31:0]         bus_rdata,
    output logic                bus_err,
    output logic [NUM_PLL-1:0]  pll_upd,
    output logic [NUM_CH-1:0]   ch_upd,
    output logic [NUM_MUX-1:0]  mux_upd
);

    localparam int unsigned KEEP_W = BUS_W - PW_W;

    logic                              wr_go, rd_go, bad, hit_lock;
    logic [NUM_PLL-1:0]                hit_pcm, hit_pana;
    logic [NUM_CH-1:0]                 hit_ch;
    logic [NUM_MUX-1:0]                hit_mctl, hit_mdiv;
    logic [NUM_PLL-1:0][KEEP_W-1:0]    pcm, pana;
    logic [NUM_CH-1:0][KEEP_W-1:0]     chw;
    logic [NUM_MUX-1:0][KEEP_W-1:0]    mctl, mdiv;
    logic [BUS_W-1:0]                  rd_word;

    clkreg_decode #(
        .ADDR_W(ADDR_W), .NUM_PLL(NUM_PLL), .NUM_CH(NUM_CH), .NUM_MUX(NUM_MUX),
        .PW_W(PW_W), .PW_KEY(PW_KEY), .LOCK_IDX(LOCK_IDX), .PLLCM_IDX(PLLCM_IDX),
        .PLLANA_IDX(PLLANA_IDX), .CH_IDX(CH_IDX), .MUX_IDX(MUX_IDX)
    ) i_decode (
        .valid_i(bus_valid), .write_i(bus_write), .addr_i(bus_addr),
        .size_i(bus_size), .pw_i(bus_wdata[BUS_W-1 -: PW_W]),
        .wr_go_o(wr_go), .rd_go_o(rd_go), .bad_o(bad), .hit_lock_o(hit_lock),
        .hit_pcm_o(hit_pcm), .hit_pana_o(hit_pana), .hit_ch_o(hit_ch),
        .hit_mctl_o(hit_mctl), .hit_mdiv_o(hit_mdiv)
    );

    clkreg_store #(
        .NUM_PLL(NUM_PLL), .NUM_CH(NUM_CH), .NUM_MUX(NUM_MUX), .KEEP_W(KEEP_W)
    ) i_store (
        .clk(clk), .rst_n(rst_n), .wr_go_i(wr_go), .wdata_i(bus_wdata[KEEP_W-1:0]),
        .hit_pcm_i(hit_pcm), .hit_pana_i(hit_pana), .hit_ch_i(hit_ch),
        .hit_mctl_i(hit_mctl), .hit_mdiv_i(hit_mdiv),
        .pcm_o(pcm), .pana_o(pana), .ch_o(chw), .mctl_o(mctl), .mdiv_o(mdiv)
    );

    clkreg_rdmux #(
        .NUM_PLL(NUM_PLL), .NUM_CH(NUM_CH), .NUM_MUX(NUM_MUX), .KEEP_W(KEEP_W),
        .ANARST_BIT(ANARST_BIT), .PWRDN_BIT(PWRDN_BIT)
    ) i_rdmux (
        .rd_go_i(rd_go), .hit_lock_i(hit_lock), .hit_pcm_i(hit_pcm),
        .hit_pana_i(hit_pana), .hit_ch_i(hit_ch), .hit_mctl_i(hit_mctl),
        .hit_mdiv_i(hit_mdiv), .pcm_i(pcm), .pana_i(pana), .ch_i(chw),
        .mctl_i(mctl), .mdiv_i(mdiv), .rdata_o(rd_word)
    );

    typedef struct packed {
        logic               rvalid;
        logic [BUS_W-1:0]   rdata;
        logic               err;
        logic [NUM_PLL-1:0] pll;
        logic [NUM_CH-1:0]  ch;
        logic [NUM_MUX-1:0] mux;
    } resp_t;

    resp_t rs_d, rs_q;

    always_comb begin
        rs_d.rvalid = bus_valid && !bus_write;
        rs_d.rdata  = rd_word;
        rs_d.err    = bad;
        for (int p = 0; p < NUM_PLL; p++) begin
            rs_d.pll[p] = wr_go && (hit_pcm[p] || hit_pana[p]);
        end
        for (int c = 0; c < NUM_CH; c++) begin
            rs_d.ch[c] = wr_go && (hit_ch[c] || hit_pcm[c / CH_PER_PLL]);
        end
        for (int m = 0; m < NUM_MUX; m++) begin
            rs_d.mux[m] = wr_go && (hit_mctl[m] || hit_mdiv[m]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign bus_rvalid = rs_q.rvalid;
    assign bus_rdata  = rs_q.rdata;
    assign bus_err    = rs_q.err;
    assign pll_upd    = rs_q.pll;
    assign ch_upd     = rs_q.ch;
    assign mux_upd    = rs_q.mux;

    AST_BADKEY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && (bus_wdata[BUS_W-1 -: PW_W] != PW_KEY[PW_W-1:0]))
        |=> (pll_upd == '0 && ch_upd == '0 && mux_upd == '0)); // R2

    AST_KEY_STRIPPED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> (bus_rdata[BUS_W-1 -: PW_W] == '0)); // R3

    AST_ILLEGAL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && ((bus_addr[1:0] != 2'b00) || (bus_size != ACC_B32)))
        |=> (bus_err && bus_rdata == '0 && pll_upd == '0 && ch_upd == '0 && mux_upd == '0)); // R4

    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_valid)); // R4

    AST_RVALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_valid || bus_write) |=> !bus_rvalid); // R5

    AST_LOCK_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && hit_lock) |=> ((bus_rdata >> NUM_PLL) == BUS_W'(0))); // R6

    AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|{pll_upd, ch_upd, mux_upd}) |-> $past(bus_valid && bus_write)); // R11

    for (genvar p = 0; p < NUM_PLL; p++) begin : g_ast_pll
        AST_SHARED_FANOUT: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_go && hit_pcm[p])
            |=> (pll_upd[p] && (&ch_upd[p*CH_PER_PLL +: CH_PER_PLL]))); // R7
        AST_ANALOG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_go && hit_pana[p]) |=> (pll_upd[p] && ch_upd == '0 && mux_upd == '0)); // R8
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ast_ch
        AST_CHAN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_go && hit_ch[c]) |=> (ch_upd[c] && pll_upd == '0 && mux_upd == '0)); // R9
    end

    for (genvar m = 0; m < NUM_MUX; m++) begin : g_ast_mux
        AST_MUX_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_go && (hit_mctl[m] || hit_mdiv[m]))
            |=> (mux_upd[m] && pll_upd == '0 && ch_upd == '0)); // R10
    end

endmodule

// File: tb/test_clkreg_bank.sv
`timescale 1ns/1ps
module test_clkreg_bank;

    localparam int NW     = 2048;
    localparam int NPLL   = 4;
    localparam int NCH    = 8;
    localparam int NMUX   = 4;
    localparam int B_PCM  = 8;
    localparam int B_PANA = 16;
    localparam int B_CH   = 32;
    localparam int B_MUX  = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rvalid, bus_err;
    logic [31:0] bus_rdata;
    logic [3:0]  pll_upd, mux_upd;
    logic [7:0]  ch_upd;

    clkreg_bank i_clkreg_bank (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .pll_upd(pll_upd), .ch_upd(ch_upd), .mux_upd(mux_upd)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] model [0:NW-1];

    logic        o_rv, o_err;
    logic [31:0] o_rd;
    logic [3:0]  o_pll, o_mux;
    logic [7:0]  o_ch;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit is_store(int i);
        return (i >= B_PCM && i < B_PCM + NPLL) || (i >= B_PANA && i < B_PANA + NPLL) ||
               (i >= B_CH && i < B_CH + NCH) || (i >= B_MUX && i < B_MUX + 2 * NMUX);
    endfunction

    function automatic logic [3:0] exp_pll(int i);
        logic [3:0] v = '0;
        for (int p = 0; p < NPLL; p++) v[p] = (i == B_PCM + p) || (i == B_PANA + p);
        return v;
    endfunction

    function automatic logic [7:0] exp_ch(int i);
        logic [7:0] v = '0;
        for (int c = 0; c < NCH; c++) v[c] = (i == B_CH + c) || (i == B_PCM + c / 2);
        return v;
    endfunction

    function automatic logic [3:0] exp_mux(int i);
        logic [3:0] v = '0;
        for (int m = 0; m < NMUX; m++) v[m] = (i == B_MUX + 2 * m) || (i == B_MUX + 2 * m + 1);
        return v;
    endfunction

    function automatic logic [31:0] exp_lock();
        logic [31:0] v = '0;
        for (int p = 0; p < NPLL; p++) v[p] = !model[B_PANA + p][16] && !model[B_PCM + p][8];
        return v;
    endfunction

    function automatic logic [23:0] pat(int i);
        logic [31:0] t = i * 32'h9E3779B1;
        return t[23:0] ^ 24'h00C3A5;
    endfunction

    task automatic acc(input logic wr, input int idx, input logic [1:0] off,
                       input logic [1:0] sz, input logic [31:0] d);
        logic [31:0] ix = idx;
        bus_valid = 1'b1;
        bus_write = wr;
        bus_addr  = {ix[10:0], off};
        bus_size  = sz;
        bus_wdata = d;
        @(negedge clk);
        o_rv = bus_rvalid; o_rd = bus_rdata; o_err = bus_err;
        o_pll = pll_upd; o_ch = ch_upd; o_mux = mux_upd;
        bus_valid = 1'b0;
        bus_write = 1'b0;
    endtask

    task automatic idle_chk(input string req);
        @(negedge clk);
        chk(req, "idle strobes", {16'h0, pll_upd, ch_upd, mux_upd}, 32'h0);
        chk(req, "idle err/rvalid", {30'h0, bus_err, bus_rvalid}, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < NW; i++) model[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "strobes after reset", {16'h0, pll_upd, ch_upd, mux_upd}, 32'h0);
        chk("R1", "err/rvalid after reset", {30'h0, bus_err, bus_rvalid}, 32'h0);
        for (int i = 0; i < 80; i++) begin
            if (is_store(i) || i == 0) begin
                acc(1'b0, i, 2'b00, 2'b10, 32'h0);
                chk("R1", $sformatf("read word %0d after reset", i), o_rd,
                    (i == 0) ? 32'h0000000F : 32'h0);
            end
        end
        idle_chk("R1");

        // Full-window write sweep: strobes per target class
        for (int i = 0; i < NW; i++) begin
            acc(1'b1, i, 2'b00, 2'b10, {8'h5A, pat(i)});
            chk("R7 R8", $sformatf("pll_upd word %0d", i), {28'h0, o_pll}, {28'h0, exp_pll(i)});
            chk("R7 R9", $sformatf("ch_upd word %0d", i), {24'h0, o_ch}, {24'h0, exp_ch(i)});
            chk("R10", $sformatf("mux_upd word %0d", i), {28'h0, o_mux}, {28'h0, exp_mux(i)});
            chk("R4", $sformatf("no err word %0d", i), {31'h0, o_err}, 32'h0);
            if (is_store(i)) model[i] = {8'h00, pat(i)};
            idle_chk("R11");
        end

        // Full-window read sweep
        for (int i = 0; i < NW; i++) begin
            acc(1'b0, i, 2'b00, 2'b10, 32'h0);
            chk("R5", $sformatf("rvalid word %0d", i), {31'h0, o_rv}, 32'h1);
            chk("R3 R5 R6", $sformatf("rdata word %0d", i), o_rd,
                (i == 0) ? exp_lock() : model[i]);
        end
        idle_chk("R5");

        // Wrong key on every stored word
        for (int i = 0; i < 80; i++) begin
            if (is_store(i)) begin
                logic [7:0] k = 8'h5A ^ (8'h01 << (i % 8));
                acc(1'b1, i, 2'b00, 2'b10, {k, ~pat(i)});
                chk("R2", $sformatf("strobes bad key word %0d", i),
                    {16'h0, o_pll, o_ch, o_mux}, 32'h0);
                acc(1'b0, i, 2'b00, 2'b10, 32'h0);
                chk("R2", $sformatf("unchanged word %0d", i), o_rd, model[i]);
            end
        end

        // Illegal offsets and sizes against a live word
        for (int off = 0; off < 4; off++) begin
            for (int sz = 0; sz < 4; sz++) begin
                if (!(off == 0 && sz == 2)) begin
                    acc(1'b1, B_PCM, off[1:0], sz[1:0], {8'h5A, 24'h123456});
                    chk("R4", $sformatf("err write off %0d size %0d", off, sz), {31'h0, o_err}, 32'h1);
                    chk("R4", "strobes illegal write", {16'h0, o_pll, o_ch, o_mux}, 32'h0);
                    idle_chk("R4");
                    acc(1'b0, B_PCM, off[1:0], sz[1:0], 32'h0);
                    chk("R4", "illegal read rvalid/err", {30'h0, o_rv, o_err}, 32'h3);
                    chk("R4", "illegal read data", o_rd, 32'h0);
                    acc(1'b0, B_PCM, 2'b00, 2'b10, 32'h0);
                    chk("R4", "word kept after illegal write", o_rd, model[B_PCM]);
                end
            end
        end

        // Lock word over all reset/power-down combinations
        for (int v = 0; v < 256; v++) begin
            logic [31:0] vv = v;
            logic [31:0] e = '0;
            for (int p = 0; p < NPLL; p++) begin
                acc(1'b1, B_PCM + p, 2'b00, 2'b10, {8'h5A, 15'h0, vv[p], 8'h00});
                model[B_PCM + p] = {16'h0, 7'h0, vv[p], 8'h00};
                acc(1'b1, B_PANA + p, 2'b00, 2'b10, {8'h5A, 7'h0, vv[NPLL + p], 16'h0});
                model[B_PANA + p] = {15'h0, vv[NPLL + p], 16'h0};
                e[p] = !vv[p] && !vv[NPLL + p];
            end
            acc(1'b0, 0, 2'b00, 2'b10, 32'h0);
            chk("R6", $sformatf("lock combo %0d", v), o_rd, e);
        end

        // Writing the lock word changes nothing
        acc(1'b1, 0, 2'b00, 2'b10, 32'h5AFFFFFF);
        chk("R6", "no strobe on lock write", {16'h0, o_pll, o_ch, o_mux}, 32'h0);
        acc(1'b0, 0, 2'b00, 2'b10, 32'h0);
        chk("R6", "lock after write", o_rd, exp_lock());

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule